// File: doc/BRIEF.md
# Burst Address and Cycle Sequencer

This block is the registered control front end of a synchronous burst memory. On every rising clock edge it samples an external word address, three chip enables, two address strobes, an advance input, a write request and a burst-order select. From them it decides whether the memory is deselected, starting a burst, stepping to the next beat, or repeating the current beat. The result appears one cycle later as an array address, a cycle-valid flag, a read-or-write flag and a deselect flag. The array, byte-lane masking and output drivers sit downstream and use these outputs.

Two strobes can start a burst. The processor strobe counts only while the primary enable is active, and it always starts a read. The controller strobe starts a read or a write according to the write request. The chip enables are looked at only when a strobe is effective. Later beats come from an internal two-bit counter, in either linear or interleaved order.

A two-state machine holds the selection. ST_OFF means deselected. ST_ON means a burst is open. A start command moves either state to ST_ON. A deselect command moves either state to ST_OFF. Next and hold commands leave the state unchanged.

Top module: `burst_seq_top`

## Requirements
- R1: After reset, cyc_desel is 1, cyc_vld is 0, cyc_wr is 0 and mem_addr is 0.
- R2: An effective processor strobe (strb_proc_n=0 with ce_a_n=0), with ce_b=1 and ce_c_n=0, starts a read at addr_i. This holds whatever wr_req is. The cycle (cyc_vld=1, cyc_wr=0, mem_addr=addr_i) appears after the sampling edge.
- R3: With the processor strobe not effective, strb_ctl_n=0 and all enables active, a burst starts at addr_i. cyc_wr equals the sampled wr_req.
- R4: With ce_a_n=1, strb_proc_n is ignored. A low strb_ctl_n then deselects. A high strb_ctl_n gives a continue or suspend.
- R5: An effective strobe while any enable is inactive (ce_a_n=1, ce_b=0 or ce_c_n=1) deselects: cyc_desel=1 and cyc_vld=0.
- R6: When no strobe is effective, the enables are ignored. An open burst continues whatever values they hold.
- R7: With order_sel=0 latched (linear), adv_n=0 and no strobe, the low two address bits increase by one modulo 4. Bits 15:2 stay fixed.
- R8: With order_sel=1 latched (interleaved), beat n has low two bits equal to the start low bits XOR (n mod 4).
- R9: adv_n=1 with no strobe repeats the current address. It gives a cycle whose cyc_wr equals wr_req.
- R10: While deselected, a continue or suspend produces no cycle and leaves cyc_desel at 1.
- R11: The beat counter keeps wrapping past four beats for as long as adv_n stays low.
- R12: The burst order is latched when a burst starts. order_sel changes in the middle of a burst have no effect on its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | External word address |
| ce_a_n | input | 1 | Primary chip enable, active low |
| ce_b | input | 1 | Second chip enable, active high |
| ce_c_n | input | 1 | Third chip enable, active low |
| strb_proc_n | input | 1 | Processor-style address strobe, active low |
| strb_ctl_n | input | 1 | Controller-style address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_req | input | 1 | 1 = write, 0 = read |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| mem_addr | output | 16 | Array address of the current cycle |
| cyc_vld | output | 1 | A cycle occurs this clock |
| cyc_wr | output | 1 | Cycle is a write |
| cyc_desel | output | 1 | Device is deselected |

## Verification
The assertions check on every cycle that deselect and a valid cycle never coincide. They also check that a processor-strobe start is always a read, that enable failures on an effective strobe deselect, and that idle strobes in the deselected state produce no cycle. At the counter they check that the upper address bits hold and that a suspend keeps the address, and they check the linear and interleaved stepping. Only the bench scenarios can show full address sequences across a wrap and order latching against mid-burst changes. The same holds for the continue path when the primary enable is off, and for recovery from deselect into a new burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [2:0] {
        CMD_DESEL    = 3'd0,
        CMD_START_RD = 3'd1,
        CMD_START_WR = 3'd2,
        CMD_NEXT     = 3'd3,
        CMD_HOLD     = 3'd4
    } cmd_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } state_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic ce_a_n,
    input  logic ce_b,
    input  logic ce_c_n,
    input  logic strb_proc_n,
    input  logic strb_ctl_n,
    input  logic adv_n,
    input  logic wr_req,
    output cmd_e cmd_o
);
    logic enables_ok;
    logic proc_eff;

    always_comb begin
        enables_ok = !ce_a_n && ce_b && !ce_c_n;
        proc_eff   = !strb_proc_n && !ce_a_n;
        if (proc_eff) begin
            cmd_o = enables_ok ? CMD_START_RD : CMD_DESEL;
        end else if (!strb_ctl_n) begin
            if (!enables_ok)  cmd_o = CMD_DESEL;
            else if (wr_req)  cmd_o = CMD_START_WR;
            else              cmd_o = CMD_START_RD;
        end else begin
            cmd_o = adv_n ? CMD_HOLD : CMD_NEXT;
        end
    end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              order_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              inter_q;
    logic [BEAT_W-1:0] low_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            inter_q <= 1'b0;
        end else if (load_i) begin
            upper_q <= addr_i[ADDR_W-1:BEAT_W];
            base_q  <= addr_i[BEAT_W-1:0];
            cnt_q   <= '0;
            inter_q <= order_i;
        end else if (step_i) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        low_w  = inter_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
        addr_o = {upper_q, low_w};
    end

    // R7, R8: upper bits fixed within a burst
    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    // R9: suspend keeps the address
    assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(addr_o));

    // R7: linear step adds one modulo the beat count
    assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && !inter_q) |=>
            addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));

    // R8: interleaved beat equals start XOR beat number
    assert_inter_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && inter_q) |=>
            (addr_o[BEAT_W-1:0] ^ base_q) == BEAT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              strb_proc_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              wr_req,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cyc_vld,
    output logic              cyc_wr,
    output logic              cyc_desel
);
    cmd_e   cmd_w;
    state_e state_q;
    state_e state_d;
    logic   load_w;
    logic   step_w;

    burst_cmd_decode u_dec (
        .ce_a_n      (ce_a_n),
        .ce_b        (ce_b),
        .ce_c_n      (ce_c_n),
        .strb_proc_n (strb_proc_n),
        .strb_ctl_n  (strb_ctl_n),
        .adv_n       (adv_n),
        .wr_req      (wr_req),
        .cmd_o       (cmd_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (cmd_w)
            CMD_START_RD, CMD_START_WR: state_d = ST_ON;
            CMD_DESEL:                  state_d = ST_OFF;
            default:                    state_d = state_q;
        endcase
        load_w = (cmd_w == CMD_START_RD) || (cmd_w == CMD_START_WR);
        step_w = (cmd_w == CMD_NEXT) && (state_q == ST_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_vld <= 1'b0;
            cyc_wr  <= 1'b0;
        end else begin
            unique case (cmd_w)
                CMD_START_RD: begin cyc_vld <= 1'b1; cyc_wr <= 1'b0; end
                CMD_START_WR: begin cyc_vld <= 1'b1; cyc_wr <= 1'b1; end
                CMD_DESEL:    begin cyc_vld <= 1'b0; cyc_wr <= 1'b0; end
                default: begin
                    cyc_vld <= (state_q == ST_ON);
                    cyc_wr  <= (state_q == ST_ON) && wr_req;
                end
            endcase
        end
    end

    assign cyc_desel = (state_q == ST_OFF);

    burst_addr_counter #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .step_i  (step_w),
        .addr_i  (addr_i),
        .order_i (order_sel),
        .addr_o  (mem_addr)
    );

    // R5: deselect and a valid cycle never coincide
    assert_desel_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_desel && cyc_vld));

    // R2: processor strobe start is always a read at the external address
    assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !ce_a_n && ce_b && !ce_c_n) |=>
            (cyc_vld && !cyc_wr && mem_addr == $past(addr_i)));

    // R5: effective strobe with an inactive enable deselects
    assert_enable_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((!strb_proc_n && !ce_a_n) || !strb_ctl_n) && !(!ce_a_n && ce_b && !ce_c_n))
            |=> (cyc_desel && !cyc_vld));

    // R10: idle strobes while deselected give no cycle
    assert_idle_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_desel && (strb_proc_n || ce_a_n) && strb_ctl_n) |=> (cyc_desel && !cyc_vld));
endmodule

// File: tb/tb_burst_seq_top.sv
`timescale 1ns/1ps
module tb_burst_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic        ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic        strb_proc_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic        wr_req = 1'b0, order_sel = 1'b0;
    logic [15:0] mem_addr;
    logic        cyc_vld, cyc_wr, cyc_desel;

    always #2 clk = ~clk;

    burst_seq_top dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
        .adv_n(adv_n), .wr_req(wr_req), .order_sel(order_sel),
        .mem_addr(mem_addr), .cyc_vld(cyc_vld), .cyc_wr(cyc_wr), .cyc_desel(cyc_desel)
    );

    typedef struct {
        logic        vld;
        logic        wr;
        logic        desel;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    // bench model of the selection and the burst
    bit        m_on = 0;
    bit [13:0] m_up = '0;
    bit [1:0]  m_base = '0, m_cnt = '0;
    bit        m_inter = 0;

    task automatic drive(input logic [2:0] en, input logic sp_n, input logic sc_n,
                         input logic av_n, input logic wr, input logic md,
                         input logic [15:0] a, input string tag);
        exp_t e;
        bit ok, peff, start, desel;
        @(negedge clk);
        {ce_a_n, ce_b, ce_c_n} = en;
        strb_proc_n = sp_n; strb_ctl_n = sc_n; adv_n = av_n;
        wr_req = wr; order_sel = md; addr_i = a;
        ok = (en == 3'b010);
        peff = !sp_n && !en[2];
        start = 0; desel = 0;
        e.tag = tag;
        if (peff || !sc_n) begin
            if (!ok) desel = 1;
            else begin
                start = 1;
                e.wr = peff ? 1'b0 : wr;
            end
        end
        if (desel) begin
            m_on = 0; e.vld = 0; e.wr = 0;
        end else if (start) begin
            m_on = 1; e.vld = 1;
            m_up = a[15:2]; m_base = a[1:0]; m_cnt = 0; m_inter = md;
        end else begin
            e.vld = m_on; e.wr = m_on && wr;
            if (m_on && !av_n) m_cnt = m_cnt + 1;
        end
        e.desel = !m_on;
        e.addr = {m_up, m_inter ? (m_base ^ m_cnt) : (m_base + m_cnt)};
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cyc_vld !== e.vld || cyc_desel !== e.desel ||
                (e.vld && (cyc_wr !== e.wr || mem_addr !== e.addr))) begin
                failures++;
                $display("FAIL %s: got vld=%b wr=%b desel=%b addr=%h expected vld=%b wr=%b desel=%b addr=%h",
                         e.tag, cyc_vld, cyc_wr, cyc_desel, mem_addr,
                         e.vld, e.wr, e.desel, e.addr);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (cyc_desel !== 1'b1 || cyc_vld !== 1'b0 || cyc_wr !== 1'b0 || mem_addr !== 16'h0) begin
            failures++;
            $display("FAIL R1: got desel=%b vld=%b wr=%b addr=%h expected 1 0 0 0000",
                     cyc_desel, cyc_vld, cyc_wr, mem_addr);
        end
        rst_n = 1'b1;
        // R10: continue and suspend while deselected
        drive(3'b010, 1, 1, 0, 0, 0, 16'h0000, "R10");
        drive(3'b010, 1, 1, 1, 1, 0, 16'h0000, "R10");
        // R2: processor start ignores the write request
        drive(3'b010, 0, 1, 1, 1, 0, 16'h1235, "R2");
        for (int i = 0; i < 5; i++) drive(3'b010, 1, 1, 0, 0, 0, 16'h0, "R7_R11");
        drive(3'b010, 1, 1, 1, 1, 0, 16'h0, "R9");
        drive(3'b010, 1, 1, 1, 0, 0, 16'h0, "R9");
        // R3: controller start write, interleaved
        drive(3'b010, 1, 0, 1, 1, 1, 16'h00A2, "R3");
        for (int i = 0; i < 3; i++) drive(3'b010, 1, 1, 0, 1, 0, 16'h0, "R8_R12");
        for (int i = 0; i < 3; i++) drive(3'b010, 1, 1, 0, 0, 1, 16'h0, "R8_R11");
        // R3: controller start read, linear, from an odd start
        drive(3'b010, 1, 0, 1, 0, 0, 16'hBEEF, "R3");
        drive(3'b010, 1, 1, 0, 0, 1, 16'h0, "R7_R12");
        // R6: enables ignored with no strobe
        drive(3'b101, 1, 1, 0, 1, 0, 16'h0, "R6");
        drive(3'b111, 1, 1, 1, 0, 0, 16'h0, "R6");
        // R4: primary enable off, processor strobe ignored, continue
        drive(3'b110, 0, 1, 0, 0, 0, 16'h4444, "R4");
        // R4: primary enable off with controller strobe deselects
        drive(3'b110, 0, 0, 0, 0, 0, 16'h4444, "R4");
        drive(3'b010, 1, 1, 0, 0, 0, 16'h0, "R10");
        // R5: each enable inactive on each strobe
        drive(3'b010, 1, 0, 1, 1, 1, 16'h7771, "R3");
        drive(3'b000, 1, 0, 1, 1, 0, 16'h0, "R5");
        drive(3'b010, 0, 1, 1, 0, 0, 16'h2222, "R2");
        drive(3'b011, 0, 1, 1, 0, 0, 16'h0, "R5");
        drive(3'b010, 1, 0, 1, 0, 0, 16'h3333, "R3");
        drive(3'b011, 1, 0, 1, 0, 0, 16'h0, "R5");
        drive(3'b010, 1, 1, 1, 1, 0, 16'h0, "R10");
        // R2: both strobes low, processor wins as read
        drive(3'b010, 0, 0, 1, 1, 1, 16'hFFFE, "R2");
        for (int i = 0; i < 4; i++) drive(3'b010, 1, 1, 0, 1, 0, 16'h0, "R8_R11");
        drive(3'b010, 1, 1, 1, 1, 0, 16'h0, "R9");
        repeat (4) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule